// File: doc/BRIEF.md
# Mode-Multiplexed Bidirectional GPIO Port

This block is an eight-bit general-purpose I/O port whose pads are shared with an external data bus. A two-bit operating-mode strap is captured while reset is held. It decides who owns the pads. In single-chip and bootstrap modes the pads belong to the port: an output latch and a per-pin direction register drive them. In expanded and test modes the pads carry the chip data bus. The bus logic supplies the outgoing byte and a drive enable, and it receives the incoming pad level. The bus cycles themselves are generated elsewhere.

Software reaches two registers through a small register interface: the output latch and the direction register. A read of the latch address never returns the latch contents. It returns the pad level after a two-flop synchronizer, whatever the direction. An open-drain option bit, taken from an option register outside the block, turns the port drivers into wired-OR drivers. A latch 0 pulls the pad low and a latch 1 releases it. The option only takes effect in single-chip mode. The pad side is modelled as per-pin output value, output enable and input level.

Top module: `gpio_mux_port`

## Requirements
- R1: While `rst_n` is low on a rising edge, the mode is captured from `mode_strap` (00 single-chip, 01 expanded, 10 bootstrap, 11 test), the direction register and latch clear to zero, and the synchronizer clears to zero. The captured mode then holds until the next reset, whatever `mode_strap` does. `gpio_mode` is 1 exactly for single-chip and bootstrap.
- R2: A write with `reg_sel`=0 stores `reg_wdata` into the output latch whatever the direction bits are. In port-owned modes `pad_out` always carries the latch, from the edge that takes the write.
- R3: A read with `reg_sel`=0 returns the pad level through two flops: a level held on `pad_in` before rising edge k appears on `reg_rdata` after edge k+1. This holds whatever the direction setting.
- R4: In port-owned modes with open-drain inactive, `pad_oe[i]` equals direction bit i (1 = output). An input pin is never driven.
- R5: In expanded and test modes, `pad_oe` is `bus_oe` on every pin and `pad_out` is `bus_dout`; direction, latch and `od_en` have no effect on the pads. `bus_din` always equals `pad_in`.
- R6: In single-chip mode with `od_en`=1, an output pin whose latch bit is 0 is driven low, and one whose latch bit is 1 has `pad_oe`=0. No pad is ever driven high.
- R7: In bootstrap mode `od_en` has no effect, and output pins are driven push-pull.
- R8: A write with `reg_sel`=1 stores the direction register without changing the latch. A read with `reg_sel`=1 returns the direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; mode strap captured while low |
| mode_strap | input | 2 | Operating mode: 00 single-chip, 01 expanded, 10 bootstrap, 11 test |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 latch / pad level, 1 direction |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| od_en | input | 1 | Open-drain option bit |
| bus_oe | input | 1 | Bus drive enable in bus-owned modes |
| bus_dout | input | 8 | Bus byte driven onto the pads in bus-owned modes |
| bus_din | output | 8 | Pad level handed to the bus logic |
| pad_in | input | 8 | Pad input level |
| pad_out | output | 8 | Pad output value |
| pad_oe | output | 8 | Pad output enable, 1 = drive |
| gpio_mode | output | 1 | 1 when the port owns the pads |

## Verification
Register writes take effect on the rising edge that samples the strobe. `pad_out` and `pad_oe` follow that edge combinationally, so they are due in the same cycle. A pad level needs two rising edges before it appears on a latch-address read. `bus_din`, `gpio_mode` and the direction readback are due as soon as their inputs or state settle. The bench drives every input on the falling edge and advances its model at the following rising edge. It compares all outputs at the next falling edge, and its model keeps a two-entry pad history so the read check uses the level from two edges back.

// File: rtl/gpio_mux_pkg.sv
// Package: shared types for the mode-multiplexed GPIO port.
// Assumes: mode strap encoding is fixed at chip level and decoded here only.
package gpio_mux_pkg;

    // Operating mode as captured from the strap during reset.
    typedef enum logic [1:0] {
        MODE_SINGLE   = 2'b00,
        MODE_EXPANDED = 2'b01,
        MODE_BOOT     = 2'b10,
        MODE_TEST     = 2'b11
    } op_mode_e;

    // Register select encoding on the register interface.
    localparam logic SEL_DATA = 1'b0;
    localparam logic SEL_DIR  = 1'b1;

    // True when the port, rather than the bus, owns the pads.
    function automatic logic port_owns_pads(op_mode_e m);
        return (m == MODE_SINGLE) || (m == MODE_BOOT);
    endfunction

    // True when the open-drain option may act in the given mode.
    function automatic logic od_permitted(op_mode_e m);
        return (m == MODE_SINGLE);
    endfunction

endpackage

// File: rtl/gpio_mode_latch.sv
// Module: captures the operating-mode strap while reset is held and
// decodes pad ownership and open-drain permission from it.
// Assumes: the strap is stable during reset; later changes are ignored.
module gpio_mode_latch
    import gpio_mux_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_strap,
    output op_mode_e   mode_q,
    output logic       gpio_own,
    output logic       od_allowed
);

    // Sample the strap on every reset edge, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= op_mode_e'(mode_strap);
        end
    end

    // Decode ownership and open-drain permission from the held mode.
    always_comb begin
        gpio_own   = port_owns_pads(mode_q);
        od_allowed = od_permitted(mode_q);
    end

    // R1: once out of reset the captured mode never changes.
    a_r1_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(mode_q));

endmodule

// File: rtl/gpio_port_regs.sv
// Module: output latch and direction register of the port.
// Assumes: one register write per cycle, selected by wr_sel; both clear on reset.
module gpio_port_regs
    import gpio_mux_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] lat_q,
    output logic [WIDTH-1:0] dir_q
);

    logic lat_we;
    logic dir_we;

    // Split the write strobe by register select.
    always_comb begin
        lat_we = wr_en && (wr_sel == SEL_DATA);
        dir_we = wr_en && (wr_sel == SEL_DIR);
    end

    // Output latch: stores writes regardless of direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (lat_we) begin
            lat_q <= wr_data;
        end
    end

    // Direction register: 1 marks an output pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (dir_we) begin
            dir_q <= wr_data;
        end
    end

    // R1: both registers leave reset cleared.
    a_r1_regs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dir_q == '0 && lat_q == '0));

    // R2: the latch only moves on a latch write.
    a_r2_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == SEL_DATA) |=> $stable(lat_q));

    // R8: the direction register only moves on a direction write.
    a_r8_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == SEL_DIR) |=> $stable(dir_q));

endmodule

// File: rtl/gpio_in_sync.sv
// Module: multi-flop synchronizer for the pad input levels.
// Assumes: STAGES >= 1; bits are synchronized independently.
module gpio_in_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage samples the raw pad level.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= async_in;
            end
        end else begin : g_next
            // Later stages shift the previous stage along.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[LAST];

endmodule

// File: rtl/gpio_pad_mux.sv
// Module: per-pin selection between port drive and bus drive, with the
// open-drain option folded into the output enable.
// Assumes: od_active is already qualified by mode; purely combinational path.
module gpio_pad_mux #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gpio_own,
    input  logic             od_active,
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] lat,
    input  logic             bus_oe,
    input  logic [WIDTH-1:0] bus_dout,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        logic port_oe;

        // Port drive: output pins drive, open-drain releases on a 1.
        always_comb begin
            port_oe = dir[i] && !(od_active && lat[i]);
        end

        // Pick the pad owner for this pin.
        always_comb begin
            if (gpio_own) begin
                pad_out[i] = lat[i];
                pad_oe[i]  = port_oe;
            end else begin
                pad_out[i] = bus_dout[i];
                pad_oe[i]  = bus_oe;
            end
        end
    end

    // R4: in port-owned modes an input pin is never driven.
    a_r4_input_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        gpio_own |-> ((pad_oe & ~dir) == '0));

    // R6: with open-drain active no pad is ever driven high.
    a_r6_od_no_high: assert property (@(posedge clk) disable iff (!rst_n)
        od_active |-> ((pad_oe & pad_out) == '0));

endmodule

// File: rtl/gpio_mux_port.sv
// Module: top of the mode-multiplexed bidirectional GPIO port.
// Captures the mode, holds latch and direction, synchronizes pad input
// for readback, and hands pad ownership to the port or the bus.
// Assumes: reg interface reads are combinational on reg_sel.
module gpio_mux_port
    import gpio_mux_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_strap,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [WIDTH-1:0] reg_wdata,
    output logic [WIDTH-1:0] reg_rdata,
    input  logic             od_en,
    input  logic             bus_oe,
    input  logic [WIDTH-1:0] bus_dout,
    output logic [WIDTH-1:0] bus_din,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic             gpio_mode
);

    op_mode_e         mode_q;
    logic             gpio_own;
    logic             od_allowed;
    logic             od_active;
    logic [WIDTH-1:0] lat_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] pin_sync;

    gpio_mode_latch i_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_strap (mode_strap),
        .mode_q     (mode_q),
        .gpio_own   (gpio_own),
        .od_allowed (od_allowed)
    );

    gpio_port_regs #(.WIDTH(WIDTH)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_sel  (reg_sel),
        .wr_data (reg_wdata),
        .lat_q   (lat_q),
        .dir_q   (dir_q)
    );

    gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    // Open-drain acts only when the option is set and the mode permits it.
    always_comb begin
        od_active = od_en && od_allowed;
    end

    gpio_pad_mux #(.WIDTH(WIDTH)) i_pads (
        .clk       (clk),
        .rst_n     (rst_n),
        .gpio_own  (gpio_own),
        .od_active (od_active),
        .dir       (dir_q),
        .lat       (lat_q),
        .bus_oe    (bus_oe),
        .bus_dout  (bus_dout),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    // Read path: latch address returns the pad level, not the latch.
    always_comb begin
        reg_rdata = (reg_sel == SEL_DIR) ? dir_q : pin_sync;
    end

    assign bus_din   = pad_in;
    assign gpio_mode = gpio_own;

    // R7: outside single-chip mode the open-drain option never acts.
    a_r7_od_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_SINGLE) |-> !od_active);

endmodule

// File: tb/test_gpio_mux_port.sv
`timescale 1ns/1ps
module test_gpio_mux_port;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode_strap;
    logic       reg_wr;
    logic       reg_sel;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       od_en;
    logic       bus_oe;
    logic [7:0] bus_dout;
    logic [7:0] bus_din;
    logic [7:0] pad_in;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;
    logic       gpio_mode;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Bench model
    int         m_mode;
    logic [7:0] m_dir, m_lat, m_h1, m_h2;

    always #2.5 clk = ~clk;

    gpio_mux_port i_gpio_mux_port (
        .clk(clk), .rst_n(rst_n), .mode_strap(mode_strap),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .od_en(od_en), .bus_oe(bus_oe),
        .bus_dout(bus_dout), .bus_din(bus_din), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .gpio_mode(gpio_mode)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic is_gpio(int m);
        return (m == 0) || (m == 2);
    endfunction

    function automatic logic [7:0] exp_oe(int m, logic [7:0] d, logic [7:0] l, logic od, logic boe);
        if (!is_gpio(m)) return {8{boe}};
        if (od && m == 0) return d & ~l;
        return d;
    endfunction

    function automatic logic [7:0] exp_out(int m, logic [7:0] l, logic [7:0] bd);
        return is_gpio(m) ? l : bd;
    endfunction

    // Compare every output against the model with inputs currently applied.
    task automatic check_all();
        string t_oe;
        if (!is_gpio(m_mode))           t_oe = "R5 pad_oe";
        else if (od_en && m_mode == 0)  t_oe = "R6 pad_oe";
        else if (od_en && m_mode == 2)  t_oe = "R7 pad_oe";
        else                            t_oe = "R4 pad_oe";
        chk(t_oe, pad_oe, exp_oe(m_mode, m_dir, m_lat, od_en, bus_oe));
        chk(is_gpio(m_mode) ? "R2 pad_out" : "R5 pad_out", pad_out, exp_out(m_mode, m_lat, bus_dout));
        if (reg_sel) chk("R8 dir read", reg_rdata, m_dir);
        else         chk("R3 pin read", reg_rdata, m_h2);
        chk("R5 bus_din", bus_din, pad_in);
        chk("R1 gpio_mode", {7'd0, gpio_mode}, {7'd0, is_gpio(m_mode)});
    endtask

    // One cycle: drive at falling edge, model at rising edge, check at next falling edge.
    task automatic step(input logic wr, input logic sel, input logic [7:0] wd,
                        input logic [7:0] pin, input logic od, input logic boe,
                        input logic [7:0] bd);
        reg_wr = wr; reg_sel = sel; reg_wdata = wd; pad_in = pin;
        od_en = od; bus_oe = boe; bus_dout = bd;
        @(posedge clk);
        if (wr) begin
            if (sel) m_dir = wd;
            else     m_lat = wd;
        end
        m_h2 = m_h1;
        m_h1 = pin;
        @(negedge clk);
        check_all();
    endtask

    task automatic do_reset(input int mode, input logic [1:0] later_strap);
        @(negedge clk);
        rst_n = 1'b0; mode_strap = 2'(mode); reg_wr = 1'b0; reg_sel = 1'b1;
        reg_wdata = 8'h00; pad_in = 8'h00; od_en = 1'b0; bus_oe = 1'b0; bus_dout = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mode_strap = later_strap;   // must be ignored after reset
        m_mode = mode; m_dir = 8'h00; m_lat = 8'h00; m_h1 = 8'h00; m_h2 = 8'h00;
        chk("R1 dir after reset", reg_rdata, 8'h00);
        chk("R1 oe after reset", pad_oe, is_gpio(mode) ? 8'h00 : 8'h00);
        check_all();
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0;
        for (int m = 0; m < 4; m++) begin
            do_reset(m, 2'(m + 1));
            // Directed: latch write while inputs, then direction, then open-drain.
            step(1, 0, 8'h5A, 8'h3C, 0, 1, 8'hC3);          // R2 latch stored while inputs
            step(0, 0, 8'h00, 8'hF0, 0, 1, 8'hC3);
            step(0, 0, 8'h00, 8'hF0, 0, 0, 8'h11);          // R3 read two edges later
            step(1, 1, 8'hFF, 8'h0F, 0, 1, 8'h96);          // R8 direction write, latch kept
            step(0, 1, 8'h00, 8'h0F, 1, 1, 8'h96);          // R6/R7 open-drain
            step(1, 0, 8'hA5, 8'h0F, 1, 0, 8'h00);
            step(1, 1, 8'h0F, 8'h55, 1, 1, 8'hFF);
            step(0, 0, 8'h00, 8'hAA, 0, 1, 8'h00);
            for (int k = 0; k < 250; k++) begin
                step(1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom),
                     1'($urandom), 1'($urandom), 8'($urandom));
            end
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule